// File: doc/BRIEF.md
# Distributed Interrupt Status Tracker

This block keeps one status bit for each of 64 distributed interrupt numbers. The bits are presented as a low word (numbers 0 to 31) and a high word (numbers 32 to 63). One 8-bit control code arrives per valid cycle. The block keeps only codes whose top two bits carry the distributed-interrupt flag value and ignores all other codes. It then reads bit 5 of the code according to a mode input. In acknowledge mode, bit 5 picks between raising and lowering number `code[4:0]`. In extended mode, bit 5 picks between the low and the high half, and every code of this kind raises a bit.

Each number has its own small state machine, `irq_cell`, with three states:
- `ST_IDLE`: the bit is clear.
- `ST_ACTIVE`: the bit is set and a timeout counter is running.
- `ST_LATCHED`: the bit is set with no timeout, because the reload value was zero.

The transitions are:
- **arm**: an accepted set moves a cell from any state to `ST_ACTIVE` when the reload is non-zero, or to `ST_LATCHED` when it is zero. A set on a bit that is already set restarts its timeout.
- **ack**: an accepted acknowledgment moves the cell to `ST_IDLE`.
- **wipe**: a software clear moves the cell to `ST_IDLE`.
- **expire**: when the timeout counter runs out, the cell moves from `ST_ACTIVE` to `ST_IDLE`.

Each cell also has a toggle-limit counter. It holds off further code-driven changes for a programmable number of cycles. Accepted sets, accepted acknowledgments, expiries and dropped events are reported as single-cycle pulses. Each pulse appears on the same edge as the status change it reports.

Top module: `irq_status_tracker`

## Requirements
- R1: A valid code whose bits 7:6 are not `2'b10` changes no status bit and raises no event pulse.
- R2: In acknowledge mode (`ext_mode`=0), a code `10_0_nnnnn` sets low-word bit n at the next clock edge and pulses `set_evt` for that same cycle.
- R3: In acknowledge mode, a code `10_1_nnnnn` clears low-word bit n at the next edge and pulses `clr_evt`. Codes in this mode never change the high word.
- R4: In extended mode (`ext_mode`=1), `10_1_nnnnn` sets bit 32+n (high-word bit n) and `10_0_nnnnn` sets low-word bit n. No code clears a bit in this mode.
- R5: With `tmo_reload`=R≠0 sampled at the set edge, the bit clears exactly R edges after that edge, and `tmo_evt` pulses with the clearing edge. A repeated set restarts the count.
- R6: When `tmo_reload` is 0 at the set edge, the bit stays set until it is acknowledged or cleared by software.
- R7: After a code-driven change of a bit, with `min_gap`=G, codes for that number at the next G edges are dropped. Each dropped code leaves the status unchanged and pulses `rej_evt`. G=0 disables this limit.
- R8: `sw_clr_we` clears, at the next edge, every bit set in `sw_clr_mask` within the word selected by `sw_clr_hi` (0 = low word, 1 = high word). The toggle limit does not block this clear.
- R9: A software clear and an accepted set of the same bit in the same cycle leave the bit set.
- R10: After reset, both status words and all event pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_valid | input | 1 | A code is present this cycle |
| code | input | 8 | Control code: flags in 7:6, selector in 5, number in 4:0 |
| ext_mode | input | 1 | 0 = acknowledge mode, 1 = extended mode |
| tmo_reload | input | TMO_W | Timeout length loaded on each set; 0 disables the timeout |
| min_gap | input | GAP_W | Toggle-limit length in cycles; 0 disables the limit |
| sw_clr_we | input | 1 | Software clear strobe |
| sw_clr_hi | input | 1 | Word select for the clear: 0 = low, 1 = high |
| sw_clr_mask | input | 32 | Bits to clear in the selected word |
| status_lo | output | 32 | Status of numbers 0 to 31 |
| status_hi | output | 32 | Status of numbers 32 to 63 |
| set_evt | output | 1 | An accepted set took effect at the last edge |
| clr_evt | output | 1 | An accepted acknowledgment took effect at the last edge |
| tmo_evt | output | 1 | A timeout cleared a bit at the last edge |
| rej_evt | output | 1 | A code was dropped by the toggle limit at the last edge |

## Verification
A cell whose state is wrong shows up as a wrong status bit on the edge right after the code that should have moved it. The bench therefore compares both full words after every event, which also exposes stray writes to neighbouring numbers. Faults in the timeout and toggle-limit counters only appear after a delay. The bench checks those bits on the edge just before the predicted change and again on the edge of the change, so a count that is off by one is reported. Event pulses are sampled in the cycle after the edge, so a pulse that is missing or arrives late is caught at once.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam logic [1:0]  DI_FLAG = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_LATCHED = 2'd2
    } cell_state_e;
endpackage

// File: rtl/irq_code_decode.sv
module irq_code_decode #(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic               code_valid,
    input  logic [7:0]         code,
    input  logic               ext_mode,
    output logic [NUM_IRQ-1:0] set_vec,
    output logic [NUM_IRQ-1:0] clr_vec
);
    import irq_trk_pkg::*;

    localparam int unsigned HALF  = NUM_IRQ / 2;
    localparam int unsigned IDX_W = $clog2(HALF);

    logic             hit;
    logic             sel;
    logic [IDX_W-1:0] idx;

    assign hit = code_valid && (code[7:6] == DI_FLAG);
    assign sel = code[5];
    assign idx = code[IDX_W-1:0];

    // Lower half: raised by selector 0 in either mode, lowered by selector 1 in acknowledge mode
    for (genvar g = 0; g < HALF; g++) begin : g_low
        assign set_vec[g] = hit && !sel && (idx == IDX_W'(g));
        assign clr_vec[g] = hit && sel && !ext_mode && (idx == IDX_W'(g));
    end

    // Upper half: raised only by selector 1 in extended mode, never lowered by a code
    for (genvar g = HALF; g < NUM_IRQ; g++) begin : g_high
        assign set_vec[g] = hit && sel && ext_mode && (idx == IDX_W'(g - HALF));
        assign clr_vec[g] = 1'b0;
    end
endmodule

// File: rtl/irq_cell.sv
module irq_cell #(
    parameter int unsigned TMO_W = 16,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic             clr_req,
    input  logic             sw_clr,
    input  logic [TMO_W-1:0] tmo_reload,
    input  logic [GAP_W-1:0] min_gap,
    output logic             bit_o,
    output logic             set_acc,
    output logic             clr_acc,
    output logic             tmo_hit,
    output logic             rej
);
    import irq_trk_pkg::*;

    cell_state_e      state, state_nx;
    logic [TMO_W-1:0] tcnt, tcnt_nx;
    logic [GAP_W-1:0] rcnt, rcnt_nx;
    logic             limited, set_ok, clr_ok, expire, toggled;

    assign limited = (rcnt != '0);
    assign set_ok  = set_req && !limited;
    assign clr_ok  = clr_req && !limited;
    assign expire  = (state == ST_ACTIVE) && (tcnt == TMO_W'(1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (set_ok) state_nx = (tmo_reload != '0) ? ST_ACTIVE : ST_LATCHED;
            end
            ST_ACTIVE: begin
                if (set_ok)                           state_nx = (tmo_reload != '0) ? ST_ACTIVE : ST_LATCHED;
                else if (clr_ok || sw_clr || expire)  state_nx = ST_IDLE;
            end
            ST_LATCHED: begin
                if (set_ok)                 state_nx = (tmo_reload != '0) ? ST_ACTIVE : ST_LATCHED;
                else if (clr_ok || sw_clr)  state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Counter next values
    always_comb begin
        toggled = (set_ok && (state == ST_IDLE)) || (clr_ok && (state != ST_IDLE));
        if (toggled)      rcnt_nx = min_gap;
        else if (limited) rcnt_nx = rcnt - 1'b1;
        else              rcnt_nx = '0;

        if (set_ok)                                    tcnt_nx = tmo_reload;
        else if (state_nx == ST_IDLE)                  tcnt_nx = '0;
        else if (state == ST_ACTIVE && tcnt != '0)     tcnt_nx = tcnt - 1'b1;
        else                                           tcnt_nx = tcnt;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            rcnt  <= '0;
        end else begin
            state <= state_nx;
            tcnt  <= tcnt_nx;
            rcnt  <= rcnt_nx;
        end
    end

    // Outputs
    always_comb begin
        bit_o   = (state != ST_IDLE);
        set_acc = set_ok;
        clr_acc = clr_ok;
        tmo_hit = expire && !set_ok && !clr_ok && !sw_clr;
        rej     = (set_req || clr_req) && limited;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ok && sw_clr) |=> bit_o) else $error("set lost to clear"); // R9
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rej && !sw_clr && !expire) |=> (bit_o == $past(bit_o))) else $error("dropped code changed bit"); // R7
    AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !set_ok) |=> !bit_o) else $error("expiry did not clear"); // R5
    AST_LATCHED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && !clr_req && !sw_clr) |=> bit_o) else $error("latched bit dropped"); // R6
endmodule

// File: rtl/irq_status_tracker.sv
module irq_status_tracker #(
    parameter int unsigned TMO_W = 16,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic [7:0]       code,
    input  logic             ext_mode,
    input  logic [TMO_W-1:0] tmo_reload,
    input  logic [GAP_W-1:0] min_gap,
    input  logic             sw_clr_we,
    input  logic             sw_clr_hi,
    input  logic [31:0]      sw_clr_mask,
    output logic [31:0]      status_lo,
    output logic [31:0]      status_hi,
    output logic             set_evt,
    output logic             clr_evt,
    output logic             tmo_evt,
    output logic             rej_evt
);
    import irq_trk_pkg::*;

    localparam int unsigned NUM_IRQ = 2 * WORD_W;

    logic [NUM_IRQ-1:0] set_vec, clr_vec, swc_vec, stat_vec;
    logic [NUM_IRQ-1:0] set_acc, clr_acc, tmo_hit, rej;

    irq_code_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .code_valid (code_valid),
        .code       (code),
        .ext_mode   (ext_mode),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec)
    );

    always_comb begin
        swc_vec = '0;
        if (sw_clr_we) begin
            if (sw_clr_hi) swc_vec[NUM_IRQ-1:WORD_W] = sw_clr_mask;
            else           swc_vec[WORD_W-1:0]       = sw_clr_mask;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cell
        irq_cell #(.TMO_W(TMO_W), .GAP_W(GAP_W)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_req    (set_vec[g]),
            .clr_req    (clr_vec[g]),
            .sw_clr     (swc_vec[g]),
            .tmo_reload (tmo_reload),
            .min_gap    (min_gap),
            .bit_o      (stat_vec[g]),
            .set_acc    (set_acc[g]),
            .clr_acc    (clr_acc[g]),
            .tmo_hit    (tmo_hit[g]),
            .rej        (rej[g])
        );
    end

    assign status_lo = stat_vec[WORD_W-1:0];
    assign status_hi = stat_vec[NUM_IRQ-1:WORD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_evt <= 1'b0;
            clr_evt <= 1'b0;
            tmo_evt <= 1'b0;
            rej_evt <= 1'b0;
        end else begin
            set_evt <= |set_acc;
            clr_evt <= |clr_acc;
            tmo_evt <= |tmo_hit;
            rej_evt <= |rej;
        end
    end

    AST_FLAG_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code[7:6] != DI_FLAG) |-> ((set_vec | clr_vec) == '0)) else $error("bad flags decoded"); // R1
    AST_EXT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> (clr_vec == '0)) else $error("ack in extended mode"); // R4
    AST_ACK_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (set_vec[NUM_IRQ-1:WORD_W] == '0)) else $error("high set in ack mode"); // R3
    AST_ONE_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec | clr_vec)) else $error("code hit several numbers"); // R2
endmodule

// File: tb/irq_status_tracker_tb.sv
module irq_status_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO_W = 16;
    localparam int GAP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             code_valid = 1'b0;
    logic [7:0]       code = '0;
    logic             ext_mode = 1'b0;
    logic [TMO_W-1:0] tmo_reload = '0;
    logic [GAP_W-1:0] min_gap = '0;
    logic             sw_clr_we = 1'b0;
    logic             sw_clr_hi = 1'b0;
    logic [31:0]      sw_clr_mask = '0;
    logic [31:0]      status_lo, status_hi;
    logic             set_evt, clr_evt, tmo_evt, rej_evt;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_tracker #(.TMO_W(TMO_W), .GAP_W(GAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
        .ext_mode(ext_mode), .tmo_reload(tmo_reload), .min_gap(min_gap),
        .sw_clr_we(sw_clr_we), .sw_clr_hi(sw_clr_hi), .sw_clr_mask(sw_clr_mask),
        .status_lo(status_lo), .status_hi(status_hi), .set_evt(set_evt),
        .clr_evt(clr_evt), .tmo_evt(tmo_evt), .rej_evt(rej_evt)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Present one code for one edge; return at the following negedge
    task automatic send(logic [7:0] c);
        code_valid = 1'b1;
        code = c;
        @(negedge clk);
        code_valid = 1'b0;
        code = '0;
    endtask

    task automatic wipe_all();
        sw_clr_we = 1'b1; sw_clr_mask = '1; sw_clr_hi = 1'b0;
        @(negedge clk);
        sw_clr_hi = 1'b1;
        @(negedge clk);
        sw_clr_we = 1'b0; sw_clr_hi = 1'b0; sw_clr_mask = '0;
    endtask

    task automatic t_reset();
        chk("R10 status", {status_hi, status_lo}, 64'd0);
        chk("R10 pulses", {set_evt, clr_evt, tmo_evt, rej_evt}, 4'd0);
    endtask

    task automatic t_filter();
        send(8'b0000_0011);
        chk("R1 flags00", {status_hi, status_lo}, 64'd0);
        send(8'b1100_0011);
        chk("R1 flags11", {status_hi, status_lo}, 64'd0);
        chk("R1 no pulse", set_evt, 1'b0);
        send(8'b0110_0011);
        chk("R1 flags01", {status_hi, status_lo}, 64'd0);
    endtask

    task automatic t_ack_mode();
        ext_mode = 1'b0;
        send(8'b1000_0100);
        chk("R2 set4", {status_hi, status_lo}, 64'h10);
        chk("R2 set_evt", set_evt, 1'b1);
        send(8'b1001_1111);
        chk("R2 set31", {status_hi, status_lo}, 64'h8000_0010);
        send(8'b1010_0100);
        chk("R3 ack4", {status_hi, status_lo}, 64'h8000_0000);
        chk("R3 clr_evt", clr_evt, 1'b1);
        send(8'b1011_1111);
        chk("R3 ack31 high untouched", {status_hi, status_lo}, 64'd0);
    endtask

    task automatic t_ext_mode();
        ext_mode = 1'b1;
        send(8'b1010_0101);
        chk("R4 high5", {status_hi, status_lo}, 64'h20_0000_0000);
        send(8'b1000_0101);
        chk("R4 low5", {status_hi, status_lo}, 64'h20_0000_0020);
        send(8'b1010_0101);
        chk("R4 no ack", {status_hi, status_lo}, 64'h20_0000_0020);
        chk("R4 no clr_evt", clr_evt, 1'b0);
        ext_mode = 1'b0;
        wipe_all();
        chk("R8 wipe both", {status_hi, status_lo}, 64'd0);
    endtask

    task automatic t_timeout();
        tmo_reload = 16'd5;
        send(8'b1000_0011);
        tmo_reload = '0;
        repeat (4) @(negedge clk);
        chk("R5 held R-1", status_lo, 32'h8);
        @(negedge clk);
        chk("R5 expired", status_lo, 32'h0);
        chk("R5 tmo_evt", tmo_evt, 1'b1);
        // restart: set, 3 edges, set again, then 5 more edges
        tmo_reload = 16'd5;
        send(8'b1000_0011);
        repeat (2) @(negedge clk);
        send(8'b1000_0011);
        repeat (4) @(negedge clk);
        chk("R5 restart held", status_lo, 32'h8);
        @(negedge clk);
        chk("R5 restart expired", status_lo, 32'h0);
        tmo_reload = '0;
        send(8'b1000_0110);
        repeat (40) @(negedge clk);
        chk("R6 no timeout", status_lo, 32'h40);
        wipe_all();
    endtask

    task automatic t_rate();
        min_gap = 8'd4;
        send(8'b1000_0111);
        chk("R7 first set", status_lo, 32'h80);
        send(8'b1010_0111);
        chk("R7 dropped ack", status_lo, 32'h80);
        chk("R7 rej_evt", rej_evt, 1'b1);
        repeat (3) @(negedge clk);
        send(8'b1010_0111);
        chk("R7 accepted after gap", status_lo, 32'h0);
        chk("R7 no rej", rej_evt, 1'b0);
        send(8'b1000_1001);
        sw_clr_we = 1'b1; sw_clr_mask = 32'h200;
        @(negedge clk);
        sw_clr_we = 1'b0; sw_clr_mask = '0;
        chk("R8 clear not limited", status_lo, 32'h0);
        min_gap = '0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_set_wins();
        sw_clr_we = 1'b1; sw_clr_mask = 32'h6;
        send(8'b1000_0010);
        sw_clr_we = 1'b0; sw_clr_mask = '0;
        chk("R9 set wins", status_lo, 32'h4);
        send(8'b1000_0001);
        sw_clr_we = 1'b1; sw_clr_hi = 1'b1; sw_clr_mask = 32'h6;
        @(negedge clk);
        sw_clr_we = 1'b0; sw_clr_hi = 1'b0; sw_clr_mask = '0;
        chk("R8 high select spares low", status_lo, 32'h6);
        wipe_all();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_filter();
                t_ack_mode();
                t_ext_mode();
                t_timeout();
                t_rate();
                t_set_wins();
            end
            begin
                repeat (5000) @(negedge clk);
                total++; bad++;
                $display("FAIL watchdog act=hung exp=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule